// File: doc/BRIEF.md
# Wakeup Source Controller with Pin Debounce

This always-on block runs from the slow clock and merges several wakeup causes into one level request for the core supply. The causes are a supply-monitor detection, a real-time timer alarm, a real-time clock alarm and a set of wakeup pins. A 32-bit mode register holds one enable per alarm-type source and a 3-bit pin debounce code. Software reaches it through a plain write strobe and a combinational read port.

Each wakeup pin is active-high. It passes through a two-flop synchronizer. It then counts as active only after it has stayed high for the number of slow-clock periods that the debounce code selects. Once raised, the wakeup request stays high until software pulses the status-clear input.

Top module: `wakeup_ctl`

## Requirements
- R1: After reset, the mode register reads 0x00000000 and `wakeReq` is low.
- R2: The mode register sits at byte offset 0x0C and can be written and read. A write to any other offset changes nothing. A read of any other offset returns zero.
- R3: Mode bit 1 enables the supply-monitor input, bit 2 the timer alarm and bit 3 the clock alarm. An enabled source that is high at a clock edge sets `wakeReq` from that edge onward.
- R4: A source whose enable bit is 0 has no effect on `wakeReq`.
- R5: Mode bits 14:12 hold the pin debounce code. Code 0 is immediate: one synchronized high sample of a pin sets `wakeReq`.
- R6: Codes 1, 2, 3, 4 and 5 require 3, 32, 512, 4096 and 32768 consecutive synchronized high samples. Codes 6 and 7 act like code 5.
- R7: If a pin drops low before its count is reached, its count restarts from zero.
- R8: A pin passes through two flops before debounce. With code 0, a pin that rises just after edge k sets `wakeReq` at edge k+3 and not before.
- R9: `wakeReq` holds until a `statusClr` pulse. A clear in a cycle where an enabled source or a qualified pin is still active leaves it set.
- R10: Mode bits other than 1, 2, 3 and 14:12 always read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| statusClr | input | 1 | One-cycle pulse that clears the wakeup request |
| supMonDet | input | 1 | Supply-monitor detection |
| rttAlarm | input | 1 | Real-time timer alarm |
| rtcAlarm | input | 1 | Real-time clock alarm |
| wakePin | input | NUM_PINS | Asynchronous active-high wakeup pins |
| wakeReq | output | 1 | Level wakeup request for the core supply |

## Verification
The assertions assume the alarm inputs are already synchronous to the slow clock. They also assume the source-to-request check sees `regAddr` at the mode offset with no write in that cycle. The bench therefore changes every input shortly after a rising edge, drives the wakeup pins only from the slow-clock domain, and leaves the address at the mode offset except while it probes other offsets. Debounce lengths are exercised just below and exactly at each threshold, so that an off-by-one in the counter shows up as a wrong request.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int DATA_W = 32;
  localparam int BIT_SM = 1;
  localparam int BIT_RTT = 2;
  localparam int BIT_RTC = 3;
  localparam int DBC_LSB = 12;
  localparam int DBC_MSB = 14;
  localparam logic [DATA_W-1:0] MODE_MASK = 32'h0000_700E;
  localparam int MAX_LEN = 32768;
  localparam int CNT_W = $clog2(MAX_LEN) + 1;
  localparam int LEN_W = CNT_W + 1;

  typedef struct packed {
    logic [2:0] periodCode;
  } dbcCtl_t;

  function automatic logic [LEN_W-1:0] periodLen(input logic [2:0] code);
    case (code)
      3'd0: periodLen = LEN_W'(1);
      3'd1: periodLen = LEN_W'(3);
      3'd2: periodLen = LEN_W'(32);
      3'd3: periodLen = LEN_W'(512);
      3'd4: periodLen = LEN_W'(4096);
      default: periodLen = LEN_W'(MAX_LEN);
    endcase
  endfunction
endpackage

// File: rtl/wkup_dbc.sv
module wkup_dbc
  import wkup_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dbcCtl_t             ctl,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinHit
);
  logic [LEN_W-1:0] needLen;
  assign needLen = periodLen(ctl.periodCode);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] syncQ;
    logic [CNT_W-1:0] runCnt;
    logic [LEN_W-1:0] runExt;

    assign runExt = {1'b0, runCnt};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= '0;
        runCnt <= '0;
      end else begin
        syncQ <= {syncQ[0], pinIn[p]};
        if (!syncQ[1]) runCnt <= '0;
        else if (runExt < needLen) runCnt <= runCnt + 1'b1;
      end
    end

    assign pinHit[p] = syncQ[1] && ((runExt + LEN_W'(1)) >= needLen);
  end
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
  import wkup_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_OFFSET = 'h0C,
  parameter int NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                statusClr,
  input  logic                supMonDet,
  input  logic                rttAlarm,
  input  logic                rtcAlarm,
  input  logic [NUM_PINS-1:0] pinHit,
  output dbcCtl_t             dbcCtl,
  output logic                wakeReq
);
  logic [DATA_W-1:0] modeQ;
  logic addrHit;
  logic srcEvent;

  assign addrHit = (regAddr == MODE_OFFSET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= '0;
    else if (regWrEn && addrHit) modeQ <= regWrData & MODE_MASK;
  end

  assign regRdData = addrHit ? modeQ : '0;
  assign dbcCtl.periodCode = modeQ[DBC_MSB:DBC_LSB];

  assign srcEvent = (modeQ[BIT_SM] && supMonDet) ||
                    (modeQ[BIT_RTT] && rttAlarm) ||
                    (modeQ[BIT_RTC] && rtcAlarm) ||
                    (|pinHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeReq <= 1'b0;
    else wakeReq <= (wakeReq && !statusClr) || srcEvent;
  end
endmodule

// File: rtl/wakeup_ctl.sv
module wakeup_ctl
  import wkup_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_OFFSET = 'h0C,
  parameter int NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic                statusClr,
  input  logic                supMonDet,
  input  logic                rttAlarm,
  input  logic                rtcAlarm,
  input  logic [NUM_PINS-1:0] wakePin,
  output logic                wakeReq
);
  dbcCtl_t dbcCtl;
  logic [NUM_PINS-1:0] pinHit;

  wkup_ctrl #(.ADDR_W(ADDR_W), .MODE_OFFSET(MODE_OFFSET), .NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .statusClr(statusClr),
    .supMonDet(supMonDet), .rttAlarm(rttAlarm), .rtcAlarm(rtcAlarm),
    .pinHit(pinHit), .dbcCtl(dbcCtl), .wakeReq(wakeReq)
  );

  wkup_dbc #(.NUM_PINS(NUM_PINS)) u_dbc (
    .clk(clk), .rstN(rstN), .ctl(dbcCtl), .pinIn(wakePin), .pinHit(pinHit)
  );
endmodule

// File: rtl/wkup_chk.sv
module wkup_chk
  import wkup_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_OFFSET = 'h0C,
  parameter int NUM_PINS = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regRdData,
  input logic                statusClr,
  input logic                supMonDet,
  input logic                rttAlarm,
  input logic                rtcAlarm,
  input logic [NUM_PINS-1:0] pinHit,
  input logic                wakeReq
);
  p_off_addr_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != MODE_OFFSET) |-> (regRdData == '0));

  p_undef_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((regRdData & ~MODE_MASK) == '0));

  p_sm_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == MODE_OFFSET && !regWrEn && regRdData[BIT_SM] && supMonDet) |=> wakeReq);

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wakeReq && !supMonDet && !rttAlarm && !rtcAlarm && !(|pinHit)) |=> !wakeReq);

  p_pin_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|pinHit) |=> wakeReq);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !statusClr) |=> wakeReq);
endmodule

bind wakeup_ctl wkup_chk #(.ADDR_W(ADDR_W), .MODE_OFFSET(MODE_OFFSET), .NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regRdData(regRdData),
  .statusClr(statusClr), .supMonDet(supMonDet), .rttAlarm(rttAlarm), .rtcAlarm(rtcAlarm),
  .pinHit(pinHit), .wakeReq(wakeReq)
);

// File: tb/wakeup_ctl_tb_top.sv
`timescale 1ns/1ps
module wakeup_ctl_tb_top;
  localparam int NP = 2;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h0C;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic statusClr = 1'b0;
  logic supMonDet = 1'b0, rttAlarm = 1'b0, rtcAlarm = 1'b0;
  logic [NP-1:0] wakePin = '0;
  logic wakeReq;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  wakeup_ctl #(.ADDR_W(8), .MODE_OFFSET(8'h0C), .NUM_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .statusClr(statusClr),
    .supMonDet(supMonDet), .rttAlarm(rttAlarm), .rtcAlarm(rtcAlarm),
    .wakePin(wakePin), .wakeReq(wakeReq)
  );

  // behavioural reference model
  logic [31:0] mMode;
  bit mReq;
  bit mS1 [NP];
  bit mS2 [NP];
  int mRun [NP];

  function automatic int needOf(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 32;
      3: return 512;
      4: return 4096;
      default: return 32768;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0;
      mReq = 0;
      for (int i = 0; i < NP; i++) begin mS1[i] = 0; mS2[i] = 0; mRun[i] = 0; end
    end else begin
      int need;
      bit hit;
      need = needOf(int'(mMode[14:12]));
      hit = 0;
      for (int i = 0; i < NP; i++) if (mS2[i] && mRun[i] + 1 >= need) hit = 1;
      if (mMode[1] && supMonDet) hit = 1;
      if (mMode[2] && rttAlarm) hit = 1;
      if (mMode[3] && rtcAlarm) hit = 1;
      mReq = (mReq && !statusClr) || hit;
      for (int i = 0; i < NP; i++) begin
        if (!mS2[i]) mRun[i] = 0;
        else if (mRun[i] < need) mRun[i] = mRun[i] + 1;
        mS2[i] = mS1[i];
        mS1[i] = wakePin[i];
      end
      if (regWrEn && regAddr == 8'h0C) mMode = regWrData & 32'h0000_700E;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [31:0] expRd;
      expRd = (regAddr == 8'h0C) ? mMode : 32'h0;
      total++;
      if (wakeReq !== mReq) begin
        bad++;
        $display("FAIL %s wakeReq act=%0b exp=%0b t=%0t", curReq, wakeReq, mReq, $time);
      end
      total++;
      if (regRdData !== expRd) begin
        bad++;
        $display("FAIL %s regRdData act=%h exp=%h t=%0t", curReq, regRdData, expRd, $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s directed act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step(1);
    regWrEn = 1'b0; regAddr = 8'h0C;
  endtask

  task automatic clr();
    statusClr = 1'b1; step(1); statusClr = 1'b0; step(1);
  endtask

  task automatic holdPin(input int idx, input int len);
    wakePin[idx] = 1'b1; step(len); wakePin[idx] = 1'b0; step(4);
  endtask

  initial begin
    #3800000;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    @(negedge clk);
    curReq = "R1";
    chk("R1", regRdData, 32'h0);
    chk("R1", {31'b0, wakeReq}, 32'h0);
    step(1);

    curReq = "R10";
    wr(8'h0C, 32'hFFFF_FFFF);
    @(negedge clk); chk("R10", regRdData, 32'h0000_700E);
    step(1); clr();
    curReq = "R2";
    wr(8'h0C, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    regAddr = 8'h10; step(1);
    @(negedge clk); chk("R2", regRdData, 32'h0);
    regAddr = 8'h0C; step(1);
    @(negedge clk); chk("R2", regRdData, 32'h0);
    step(1);

    curReq = "R4";
    supMonDet = 1; rttAlarm = 1; rtcAlarm = 1; step(3);
    supMonDet = 0; rttAlarm = 0; rtcAlarm = 0; step(1);
    @(negedge clk); chk("R4", {31'b0, wakeReq}, 32'h0);
    step(1);

    curReq = "R3";
    wr(8'h0C, 32'h2);
    rttAlarm = 1; rtcAlarm = 1; step(2); rttAlarm = 0; rtcAlarm = 0; step(1);
    @(negedge clk); chk("R4", {31'b0, wakeReq}, 32'h0);
    step(1);
    supMonDet = 1; step(1); supMonDet = 0;
    @(negedge clk); chk("R3", {31'b0, wakeReq}, 32'h1);
    step(1); clr();
    wr(8'h0C, 32'h4);
    rttAlarm = 1; step(1); rttAlarm = 0;
    @(negedge clk); chk("R3", {31'b0, wakeReq}, 32'h1);
    step(1); clr();
    wr(8'h0C, 32'h8);
    rtcAlarm = 1; step(1); rtcAlarm = 0;
    @(negedge clk); chk("R3", {31'b0, wakeReq}, 32'h1);
    step(1);

    curReq = "R9";
    step(5);
    @(negedge clk); chk("R9", {31'b0, wakeReq}, 32'h1);
    step(1);
    rtcAlarm = 1; clr(); step(1);
    @(negedge clk); chk("R9", {31'b0, wakeReq}, 32'h1);
    step(1);
    rtcAlarm = 0; step(1); clr();
    @(negedge clk); chk("R9", {31'b0, wakeReq}, 32'h0);
    step(1);
    wr(8'h0C, 32'h0);

    curReq = "R8";
    wakePin[0] = 1'b1;
    @(negedge clk); chk("R8", {31'b0, wakeReq}, 32'h0);
    step(1); @(negedge clk); chk("R8", {31'b0, wakeReq}, 32'h0);
    step(1); @(negedge clk); chk("R8", {31'b0, wakeReq}, 32'h0);
    step(1); @(negedge clk); chk("R8", {31'b0, wakeReq}, 32'h1);
    step(1);
    wakePin[0] = 1'b0; step(4); clr();

    curReq = "R5";
    holdPin(1, 1);
    chk("R5", {31'b0, wakeReq}, 32'h1);
    clr();

    curReq = "R6";
    for (int code = 1; code <= 4; code++) begin
      int n;
      n = needOf(code);
      wr(8'h0C, 32'(code) << 12);
      holdPin(code % 2, n - 1);
      chk("R6", {31'b0, wakeReq}, 32'h0);
      holdPin(code % 2, n);
      chk("R6", {31'b0, wakeReq}, 32'h1);
      clr();
    end
    wr(8'h0C, 32'h5000);
    holdPin(0, 32768);
    chk("R6", {31'b0, wakeReq}, 32'h1);
    clr();
    wr(8'h0C, 32'h6000);
    holdPin(1, 32767);
    chk("R6", {31'b0, wakeReq}, 32'h0);
    wr(8'h0C, 32'h7000);
    holdPin(0, 32768);
    chk("R6", {31'b0, wakeReq}, 32'h1);
    clr();

    curReq = "R7";
    wr(8'h0C, 32'h2000);
    wakePin[0] = 1'b1; step(20); wakePin[0] = 1'b0; step(1);
    wakePin[0] = 1'b1; step(20); wakePin[0] = 1'b0; step(4);
    chk("R7", {31'b0, wakeReq}, 32'h0);
    holdPin(0, 32);
    chk("R7", {31'b0, wakeReq}, 32'h1);
    clr();

    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule